// File: doc/BRIEF.md
# Subscriber Line Switch State Controller

This block is the digital control core of a line card access device that replaces electromechanical relays with six solid-state switches: a tip and a ring line-break switch, a ringing-return switch, a ringing-access switch, and a tip and a ring test-in switch. Two command bits, ring and test, select one of four line states. The decoded state drives one enable per switch.

The command bits pass through a level-sensitive capture stage that is either transparent or frozen. Three overrides act after that stage and can only turn switches off. The first is a shutdown pin that can be forced low or forced high. The second is an over-temperature flag. The third is a battery monitor with hysteresis, fed by two comparator flags. The ringing-access switch also has a release rule: once on, it stays on until a zero-current-crossing pulse arrives, whatever the commands or overrides say.

A parameter selects between two variants. The base variant has a test-in state. The other variant replaces it with a test-monitor state.

Top module: `line_switch_ctrl`

## Requirements
- R1: With command bits {ring,test} = 2'b00 (idle/talk), both break enables are 1 and the ringing-return, ringing-access and both test-in enables are 0.
- R2: With command 2'b10 (ringing), the ringing-return and ringing-access enables are 1, and the break and test-in enables are 0.
- R3: With command 2'b01, the base variant (MONITOR_STATE=0) drives only the two test-in enables to 1. The monitor variant (MONITOR_STATE=1) drives both break and both test-in enables to 1, with the ringing enables at 0.
- R4: With command 2'b11 (all-off), every enable is 0.
- R5: While `hold` is 0, the commands reach the enables in the same cycle. While `hold` is 1, the enables follow the command captured at the last rising clock edge before `hold` went high, and changes on the command pins are ignored.
- R6: While `tsd_force_low` is 1, the break, ringing-return and test-in enables are 0 in that cycle, regardless of the commands and of `hold`.
- R7: While `overtemp` is 1 and `tsd_force_high` is 0, the same enables are forced to 0 and `tsd_status` is 0. When `overtemp` returns to 0, the enables return to the currently commanded state in the same cycle.
- R8: While `tsd_force_high` is 1, `overtemp` has no effect on the enables, and `tsd_status` stays 1.
- R9: Once the ringing-access enable is 1, it stays 1 after its request is withdrawn, including withdrawal by any override. It drops on the cycle after a cycle with `zero_cross`=1 and no request. The ringing-return enable drops in the same cycle its request is withdrawn.
- R10: A cycle with `batt_above_hi`=1 sets a battery fault from the next cycle on. A cycle with `batt_below_lo`=1 and `batt_above_hi`=0 clears it from the next cycle on. While the fault is set, the enables are forced off as in R6.
- R11: After reset, the battery fault is set, the captured command is 2'b11, and every enable is 0.
- R12: The break enables and the ringing-return enable are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_cmd | input | 1 | Ring command bit |
| test_cmd | input | 1 | Test command bit |
| hold | input | 1 | 1 freezes the captured command, 0 is transparent |
| tsd_force_low | input | 1 | Shutdown pin driven low externally: force off |
| tsd_force_high | input | 1 | Shutdown pin driven high externally: thermal shutdown disabled |
| overtemp | input | 1 | Over-temperature flag |
| batt_above_hi | input | 1 | Battery comparator: battery above -10 V |
| batt_below_lo | input | 1 | Battery comparator: battery below -15 V |
| zero_cross | input | 1 | Zero-current-crossing pulse from the ringing path |
| brk_tip_en | output | 1 | Tip line-break switch enable |
| brk_ring_en | output | 1 | Ring line-break switch enable |
| ring_ret_en | output | 1 | Ringing-return switch enable |
| ring_acc_en | output | 1 | Ringing-access switch enable |
| tst_tip_en | output | 1 | Tip test-in switch enable |
| tst_ring_en | output | 1 | Ring test-in switch enable |
| tsd_status | output | 1 | Shutdown status, 0 while thermal shutdown is active |

## Verification
The bench builds two copies side by side from the same stimulus: one with MONITOR_STATE=1 and one with MONITOR_STATE=0. This puts both meanings of command 2'b01 within reach in every vector. Random stimulus with rare zero-cross pulses leaves the ringing-access switch on across many command and override changes, which exercises the delayed release. Overlapping overrides and battery flags, including both comparator flags high in the same cycle, cover the priority and hysteresis of the battery fault.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int CMD_W = 2;

  typedef struct packed {
    logic brk_tip;
    logic brk_ring;
    logic ring_ret;
    logic ring_acc;
    logic tst_tip;
    logic tst_ring;
  } sw_t;

  localparam sw_t SW_OFF = '0;

  typedef enum logic [CMD_W-1:0] {
    CMD_IDLE  = 2'b00,
    CMD_TEST  = 2'b01,
    CMD_RING  = 2'b10,
    CMD_ALLOFF = 2'b11
  } cmd_e;
endpackage

// File: rtl/lsc_cmd_latch.sv
module lsc_cmd_latch
  import lsc_pkg::*;
#(
  parameter int W = CMD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] cmd_in,
  output logic [W-1:0] cmd_eff
);
  logic [W-1:0] cap_q;

  // Transparent while hold is low; frozen copy otherwise.
  assign cmd_eff = hold ? cap_q : cmd_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= {W{1'b1}};
    else        cap_q <= cmd_eff;
  end
endmodule

// File: rtl/lsc_decode.sv
module lsc_decode
  import lsc_pkg::*;
#(
  parameter bit MONITOR_STATE = 1'b0
) (
  input  logic [CMD_W-1:0] cmd,
  output sw_t              sw
);
  sw_t test_pat;

  generate
    if (MONITOR_STATE) begin : g_monitor
      always_comb begin
        test_pat          = SW_OFF;
        test_pat.brk_tip  = 1'b1;
        test_pat.brk_ring = 1'b1;
        test_pat.tst_tip  = 1'b1;
        test_pat.tst_ring = 1'b1;
      end
    end else begin : g_base
      always_comb begin
        test_pat          = SW_OFF;
        test_pat.tst_tip  = 1'b1;
        test_pat.tst_ring = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    sw = SW_OFF;
    unique case (cmd_e'(cmd))
      CMD_IDLE: begin
        sw.brk_tip  = 1'b1;
        sw.brk_ring = 1'b1;
      end
      CMD_RING: begin
        sw.ring_ret = 1'b1;
        sw.ring_acc = 1'b1;
      end
      CMD_TEST:   sw = test_pat;
      CMD_ALLOFF: sw = SW_OFF;
      default:    sw = SW_OFF;
    endcase
  end
endmodule

// File: rtl/lsc_guard.sv
module lsc_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic tsd_force_low,
  input  logic tsd_force_high,
  input  logic overtemp,
  input  logic batt_above_hi,
  input  logic batt_below_lo,
  output logic force_off,
  output logic thermal_trip
);
  logic batt_fault_q;

  // Fault set dominates clear: hysteresis between the two thresholds.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             batt_fault_q <= 1'b1;
    else if (batt_above_hi) batt_fault_q <= 1'b1;
    else if (batt_below_lo) batt_fault_q <= 1'b0;
  end

  assign thermal_trip = overtemp & ~tsd_force_high;
  assign force_off    = tsd_force_low | thermal_trip | batt_fault_q;
endmodule

// File: rtl/lsc_acc_release.sv
module lsc_acc_release (
  input  logic clk,
  input  logic rst_n,
  input  logic want_on,
  input  logic zero_cross,
  output logic acc_en
);
  logic stuck_q;

  // Once conducting, only a zero-current crossing may release it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stuck_q <= 1'b0;
    else if (want_on)    stuck_q <= 1'b1;
    else if (zero_cross) stuck_q <= 1'b0;
  end

  assign acc_en = want_on | stuck_q;
endmodule

// File: rtl/line_switch_ctrl.sv
module line_switch_ctrl
  import lsc_pkg::*;
#(
  parameter bit MONITOR_STATE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ring_cmd,
  input  logic test_cmd,
  input  logic hold,
  input  logic tsd_force_low,
  input  logic tsd_force_high,
  input  logic overtemp,
  input  logic batt_above_hi,
  input  logic batt_below_lo,
  input  logic zero_cross,
  output logic brk_tip_en,
  output logic brk_ring_en,
  output logic ring_ret_en,
  output logic ring_acc_en,
  output logic tst_tip_en,
  output logic tst_ring_en,
  output logic tsd_status
);
  logic [CMD_W-1:0] cmd_eff;
  sw_t              dec_sw;
  sw_t              gated_sw;
  logic             force_off;
  logic             thermal_trip;

  lsc_cmd_latch #(.W(CMD_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold),
    .cmd_in  ({ring_cmd, test_cmd}),
    .cmd_eff (cmd_eff)
  );

  lsc_decode #(.MONITOR_STATE(MONITOR_STATE)) u_decode (
    .cmd (cmd_eff),
    .sw  (dec_sw)
  );

  lsc_guard u_guard (
    .clk            (clk),
    .rst_n          (rst_n),
    .tsd_force_low  (tsd_force_low),
    .tsd_force_high (tsd_force_high),
    .overtemp       (overtemp),
    .batt_above_hi  (batt_above_hi),
    .batt_below_lo  (batt_below_lo),
    .force_off      (force_off),
    .thermal_trip   (thermal_trip)
  );

  assign gated_sw = force_off ? SW_OFF : dec_sw;

  lsc_acc_release u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .want_on    (gated_sw.ring_acc),
    .zero_cross (zero_cross),
    .acc_en     (ring_acc_en)
  );

  assign brk_tip_en  = gated_sw.brk_tip;
  assign brk_ring_en = gated_sw.brk_ring;
  assign ring_ret_en = gated_sw.ring_ret;
  assign tst_tip_en  = gated_sw.tst_tip;
  assign tst_ring_en = gated_sw.tst_ring;
  assign tsd_status  = ~thermal_trip;
endmodule

// File: rtl/line_switch_ctrl_chk.sv
module line_switch_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ring_cmd,
  input logic test_cmd,
  input logic hold,
  input logic tsd_force_low,
  input logic tsd_force_high,
  input logic overtemp,
  input logic batt_above_hi,
  input logic batt_below_lo,
  input logic zero_cross,
  input logic brk_tip_en,
  input logic brk_ring_en,
  input logic ring_ret_en,
  input logic ring_acc_en,
  input logic tst_tip_en,
  input logic tst_ring_en,
  input logic tsd_status
);
  logic quiet;
  assign quiet = !(brk_tip_en || brk_ring_en || ring_ret_en || tst_tip_en || tst_ring_en);

  assert_tsd_low_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_force_low |-> quiet);

  assert_thermal_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overtemp && !tsd_force_high) |-> (quiet && !tsd_status));

  assert_thermal_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_force_high |-> tsd_status);

  assert_acc_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ring_acc_en) |-> $past(zero_cross));

  assert_batt_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    batt_above_hi |=> quiet);

  assert_break_ret_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !((brk_tip_en || brk_ring_en) && ring_ret_en));

  assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold) && !tsd_force_low && !overtemp && !batt_above_hi && !batt_below_lo
     && !$past(tsd_force_low) && !$past(overtemp) && !$past(batt_above_hi) && !$past(batt_below_lo))
    |-> ($stable(brk_tip_en) && $stable(ring_ret_en) && $stable(tst_tip_en)));
endmodule

bind line_switch_ctrl line_switch_ctrl_chk u_chk (.*);

// File: tb/line_switch_ctrl_test.sv
`timescale 1ns/1ps
module line_switch_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ring_cmd = 1'b1, test_cmd = 1'b1, hold = 1'b0;
  logic tsd_force_low = 1'b0, tsd_force_high = 1'b0, overtemp = 1'b0;
  logic batt_above_hi = 1'b0, batt_below_lo = 1'b0, zero_cross = 1'b0;

  logic [6:0] out_m, out_b;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // model state
  logic [1:0] m_cmd = 2'b11;
  logic       m_fault = 1'b1;
  logic       m_acc_m = 1'b0, m_acc_b = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  line_switch_ctrl #(.MONITOR_STATE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .ring_cmd(ring_cmd), .test_cmd(test_cmd), .hold(hold),
    .tsd_force_low(tsd_force_low), .tsd_force_high(tsd_force_high), .overtemp(overtemp),
    .batt_above_hi(batt_above_hi), .batt_below_lo(batt_below_lo), .zero_cross(zero_cross),
    .brk_tip_en(out_m[6]), .brk_ring_en(out_m[5]), .ring_ret_en(out_m[4]), .ring_acc_en(out_m[3]),
    .tst_tip_en(out_m[2]), .tst_ring_en(out_m[1]), .tsd_status(out_m[0]));

  line_switch_ctrl #(.MONITOR_STATE(1'b0)) uut_b (
    .clk(clk), .rst_n(rst_n), .ring_cmd(ring_cmd), .test_cmd(test_cmd), .hold(hold),
    .tsd_force_low(tsd_force_low), .tsd_force_high(tsd_force_high), .overtemp(overtemp),
    .batt_above_hi(batt_above_hi), .batt_below_lo(batt_below_lo), .zero_cross(zero_cross),
    .brk_tip_en(out_b[6]), .brk_ring_en(out_b[5]), .ring_ret_en(out_b[4]), .ring_acc_en(out_b[3]),
    .tst_tip_en(out_b[2]), .tst_ring_en(out_b[1]), .tsd_status(out_b[0]));

  // order: brk_tip brk_ring ring_ret ring_acc tst_tip tst_ring
  function automatic logic [5:0] decode(logic [1:0] c, bit mon);
    case (c)
      2'b00:   return 6'b110000;  // R1
      2'b10:   return 6'b001100;  // R2
      2'b01:   return mon ? 6'b110011 : 6'b000011;  // R3
      default: return 6'b000000;  // R4
    endcase
  endfunction

  function automatic string req_of(logic [1:0] c, logic fo);
    if (tsd_force_low) return "R6";
    if (overtemp && !tsd_force_high) return "R7";
    if (overtemp) return "R8";
    if (fo) return "R10";
    if (hold) return "R5";
    case (c)
      2'b00: return "R1";
      2'b10: return "R2";
      2'b01: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check_one(logic [6:0] act, logic [6:0] exp, string tag, string which);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) t=%0t actual=%b expected=%b", tag, which, $time, act, exp);
    end
  endtask

  // Applies the current inputs for one cycle, checks before the edge, then advances the model.
  task automatic step(string tag);
    logic [1:0] eff;
    logic fo, therm;
    logic [5:0] wm, wb;
    logic [6:0] em, eb;
    string t;
    #2;
    eff   = hold ? m_cmd : {ring_cmd, test_cmd};
    therm = overtemp & ~tsd_force_high;
    fo    = tsd_force_low | therm | m_fault;
    wm    = fo ? 6'b0 : decode(eff, 1'b1);
    wb    = fo ? 6'b0 : decode(eff, 1'b0);
    em    = {wm[5:4], wm[3], wm[2] | m_acc_m, wm[1:0], ~therm};
    eb    = {wb[5:4], wb[3], wb[2] | m_acc_b, wb[1:0], ~therm};
    t = (tag == "") ? req_of(eff, fo) : tag;
    if (out_m[3] !== em[3] || out_b[3] !== eb[3]) t = "R9";
    check_one(out_m, em, t, "monitor");
    check_one(out_b, eb, t, "base");
    @(posedge clk);
    if (rst_n) begin
      m_cmd   = eff;
      m_fault = batt_above_hi ? 1'b1 : (batt_below_lo ? 1'b0 : m_fault);
      m_acc_m = wm[2] ? 1'b1 : (zero_cross ? 1'b0 : m_acc_m);
      m_acc_b = wb[2] ? 1'b1 : (zero_cross ? 1'b0 : m_acc_b);
    end
    @(negedge clk);
  endtask

  task automatic setc(logic r, logic t, logic h);
    ring_cmd = r; test_cmd = t; hold = h;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    @(negedge clk);
    step("R11");
    step("R11");
    rst_n = 1'b1;
    @(negedge clk);
    setc(1'b0, 1'b0, 1'b0);
    step("R11");                    // battery fault still set after reset
    batt_below_lo = 1'b1;
    step("R10");                    // clear takes effect next cycle
    batt_below_lo = 1'b0;
    step("R1"); step("R1");
    setc(1'b1, 1'b0, 1'b0); step("R2"); step("R2");
    setc(1'b0, 1'b0, 1'b0); step("R9"); step("R9"); step("R9");   // access held on
    zero_cross = 1'b1; step("R9");
    zero_cross = 1'b0; step("R9");  // released now
    setc(1'b0, 1'b1, 1'b0); step("R3"); step("R3");
    setc(1'b1, 1'b1, 1'b0); step("R4");
    setc(1'b1, 1'b0, 1'b0); step("R2");
    hold = 1'b1; setc(1'b0, 1'b0, 1'b1); step("R5"); step("R5");  // frozen at ringing
    setc(1'b0, 1'b1, 1'b1); step("R5");
    hold = 1'b0; step("R5");
    setc(1'b0, 1'b0, 1'b0); zero_cross = 1'b1; step("R9");
    zero_cross = 1'b0; step("R1");
    tsd_force_low = 1'b1; hold = 1'b1; step("R6"); step("R6");
    tsd_force_low = 1'b0; hold = 1'b0; step("R6");
    overtemp = 1'b1; step("R7"); step("R7");
    overtemp = 1'b0; step("R7");
    overtemp = 1'b1; tsd_force_high = 1'b1; step("R8"); step("R8");
    overtemp = 1'b0; tsd_force_high = 1'b0;
    batt_above_hi = 1'b1; step("R10");
    batt_above_hi = 1'b0; step("R10"); step("R10");
    batt_above_hi = 1'b1; batt_below_lo = 1'b1; step("R10");
    batt_above_hi = 1'b0; step("R10");
    batt_below_lo = 1'b0; step("R10"); step("R12");
    for (int i = 0; i < 6000; i++) begin
      ring_cmd       = $urandom_range(0, 1);
      test_cmd       = $urandom_range(0, 1);
      hold           = ($urandom_range(0, 5) == 0);
      tsd_force_low  = ($urandom_range(0, 19) == 0);
      tsd_force_high = ($urandom_range(0, 9) == 0);
      overtemp       = ($urandom_range(0, 14) == 0);
      batt_above_hi  = ($urandom_range(0, 39) == 0);
      batt_below_lo  = ($urandom_range(0, 7) == 0);
      zero_cross     = ($urandom_range(0, 11) == 0);
      step("");
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule